// File: doc/BRIEF.md
# Page-Gated On-Chip RAM Controller

This block fronts a small single-port on-chip RAM that is divided into four equal pages. A control register holds one enable bit per page. The register sits behind a byte-only register port. A separate RAM port carries data reads, instruction fetches and writes. Each RAM access is admitted or gated according to the enable bit of the page it addresses. A gated write is dropped. A gated read returns a fixed marker word.

Every page has a one-entry write buffer. A write to a page is parked in that page's buffer. It reaches the array only when the next access to the same page arrives, whether that access is a read or a write. A read that hits the parked address is answered from the buffer. If software clears a page's enable bit while that page still holds a parked write, the parked write is thrown away. To avoid that loss, software must touch the page once before disabling it.

The block has two resets. The power-on reset initialises everything. The manual reset only clears the read-return stage, and the enables and parked writes survive it. While the standby input is high, both ports are frozen.

Top module: `pgram_ctrl`

## Requirements
- R1: After power-on reset the control register reads 0xFF, so all four pages are enabled.
- R2: A register write with size code 2'b00 (byte) loads bits 3..0 from write data, where bit n enables page n. Size codes 2'b01 (word) and 2'b10 (longword) leave the register unchanged. Bits 7..4 always read as 1.
- R3: While standby_i is high, register writes and RAM requests are ignored. Neither manual reset nor standby changes the control register.
- R4: For a read request accepted at a clock edge, ram_rvalid_o is 1 and ram_rdata_o carries the data after that same edge. An instruction fetch (ram_ifetch_i=1) returns the same data as a data read.
- R5: The page is taken from the two most significant bits of ram_addr_i. On an enabled page, a read returns the most recent data written to that word, including a write that is still parked in the page's buffer.
- R6: While a page's enable bit is 0, writes to it leave the array unchanged and reads from it return 0xDEADBEEF.
- R7: A write is parked in its page's buffer and is committed to the array by the next read or write to the same page. Accesses to other pages do not commit it.
- R8: Clearing a page's enable bit while that page holds a parked write discards the parked write. After re-enabling, the word reads back its previously committed value.
- R9: A RAM access issued in the same cycle as a register write is judged with the enables that held before that write. If such a write to page n coincides with clearing bit n, the older parked entry is committed and the new write is discarded. An access in the following cycle uses the new enables.
- R10: Manual reset forces ram_rvalid_o low at once and keeps parked writes, which are still returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| standby_i | input | 1 | Standby indication; freezes both ports |
| reg_sel_i | input | 1 | Register port select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_size_i | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current control register value |
| ram_req_i | input | 1 | RAM access request |
| ram_wr_i | input | 1 | 1 write, 0 read |
| ram_ifetch_i | input | 1 | Marks a read as instruction fetch |
| ram_addr_i | input | AW | Word address; top two bits select the page |
| ram_wdata_i | input | DW | RAM write data |
| ram_rdata_o | output | DW | RAM read data |
| ram_rvalid_o | output | 1 | Read data valid |

## Verification
Two functions can land in the same cycle: a control-register write that clears a page's enable bit, and a RAM access to that same page. The outcome depends on which enable set governs the access and on what happens to the parked write. The bench provokes this collision with directed cases and with a random share of cycles that drive both ports together. It then reads the affected words back after re-enabling the page. Those values are judged against a bench model that applies the RAM access under the old enables first and then the register update.

// File: rtl/pgram_pkg.sv
package pgram_pkg;

    localparam int PAGE_BITS = 2;
    localparam int NUM_PAGES = 1 << PAGE_BITS;
    localparam int CTRL_W    = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam logic [31:0] GATED_WORD = 32'hDEAD_BEEF;

endpackage

// File: rtl/pgram_ctrl_reg.sv
module pgram_ctrl_reg
    import pgram_pkg::*;
#(
    parameter int NPAGE = NUM_PAGES
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              standby_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [1:0]        size_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [NPAGE-1:0]  en_o,
    output logic [NPAGE-1:0]  fall_o,
    output logic [CTRL_W-1:0] rdata_o
);

    typedef struct packed {
        logic [NPAGE-1:0] en;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     wr_ok;

    always_comb begin
        st_d  = st_q;
        wr_ok = sel_i && wr_i && !standby_i && (acc_size_e'(size_i) == SZ_BYTE);
        if (wr_ok) begin
            st_d.en = wdata_i[NPAGE-1:0];
        end
        fall_o = st_q.en & ~st_d.en;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.en <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign rdata_o = {{(CTRL_W-NPAGE){1'b1}}, st_q.en};

    AST_SIZE_GUARD: assert property (@(posedge clk) disable iff (!por_n)
        (sel_i && wr_i && size_i != 2'b00) |=> $stable(en_o)); // R2
    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        standby_i |=> $stable(en_o)); // R3

endmodule

// File: rtl/pgram_wbuf.sv
module pgram_wbuf #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          acc_i,
    input  logic          wr_i,
    input  logic          kill_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          commit_o
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wb_st_t;

    wb_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        commit_o = acc_i && st_q.valid;
        if (kill_i) begin
            st_d.valid = 1'b0;
        end else if (acc_i && wr_i) begin
            st_d.valid = 1'b1;
            st_d.addr  = addr_i;
            st_d.data  = data_i;
        end else if (acc_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;

    AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!por_n)
        kill_i |=> !valid_o); // R8
    AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!por_n)
        (acc_i && !wr_i) |=> !valid_o); // R7
    AST_WRITE_PARKS: assert property (@(posedge clk) disable iff (!por_n)
        (acc_i && wr_i && !kill_i) |=> (valid_o && addr_o == $past(addr_i))); // R7

endmodule

// File: rtl/pgram_array.sv
module pgram_array #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/pgram_ctrl.sv
module pgram_ctrl
    import pgram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              standby_i,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_size_i,
    input  logic [CTRL_W-1:0] reg_wdata_i,
    output logic [CTRL_W-1:0] reg_rdata_o,
    input  logic              ram_req_i,
    input  logic              ram_wr_i,
    input  logic              ram_ifetch_i,
    input  logic [AW-1:0]     ram_addr_i,
    input  logic [DW-1:0]     ram_wdata_i,
    output logic [DW-1:0]     ram_rdata_o,
    output logic              ram_rvalid_o
);

    localparam int PB    = PAGE_BITS;
    localparam int NPAGE = NUM_PAGES;
    localparam logic [DW-1:0] GATE = DW'(GATED_WORD);

    typedef struct packed {
        logic          rvalid;
        logic          gated;
        logic          fwd;
        logic [DW-1:0] fdata;
    } rd_st_t;

    logic [NPAGE-1:0] en, fall, acc, commit_v, b_valid;
    logic [AW-1:0]    b_addr [NPAGE];
    logic [DW-1:0]    b_data [NPAGE];
    logic [PB-1:0]    page;
    logic             live, acc_ok, rd_req, hit;
    logic             arr_we;
    logic [AW-1:0]    arr_waddr;
    logic [DW-1:0]    arr_wdata, arr_rdata;
    logic             rst_n;
    rd_st_t           rd_d, rd_q;

    pgram_ctrl_reg #(.NPAGE(NPAGE)) u_ctrl_reg (
        .clk       (clk),
        .por_n     (por_n),
        .standby_i (standby_i),
        .sel_i     (reg_sel_i),
        .wr_i      (reg_wr_i),
        .size_i    (reg_size_i),
        .wdata_i   (reg_wdata_i),
        .en_o      (en),
        .fall_o    (fall),
        .rdata_o   (reg_rdata_o)
    );

    assign page   = ram_addr_i[AW-1 -: PB];
    assign live   = ram_req_i && !standby_i;
    assign acc_ok = live && en[page];

    for (genvar p = 0; p < NPAGE; p++) begin : g_page
        assign acc[p] = acc_ok && (page == PB'(p));

        pgram_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
            .clk      (clk),
            .por_n    (por_n),
            .acc_i    (acc[p]),
            .wr_i     (ram_wr_i),
            .kill_i   (fall[p]),
            .addr_i   (ram_addr_i),
            .data_i   (ram_wdata_i),
            .valid_o  (b_valid[p]),
            .addr_o   (b_addr[p]),
            .data_o   (b_data[p]),
            .commit_o (commit_v[p])
        );
    end

    assign arr_we    = |commit_v;
    assign arr_waddr = b_addr[page];
    assign arr_wdata = b_data[page];

    pgram_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .we_i    (arr_we),
        .waddr_i (arr_waddr),
        .wdata_i (arr_wdata),
        .raddr_i (ram_addr_i),
        .rdata_o (arr_rdata)
    );

    // Instruction fetch and data read share one path.
    assign rd_req = live && !ram_wr_i && (ram_ifetch_i || !ram_ifetch_i);
    assign hit    = b_valid[page] && (b_addr[page] == ram_addr_i);

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = rd_req;
        rd_d.gated  = rd_req && !en[page];
        rd_d.fwd    = rd_req && hit;
        if (rd_req && hit) begin
            rd_d.fdata = b_data[page];
        end
    end

    assign rst_n = por_n && mrst_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        if (!rd_q.rvalid) begin
            ram_rdata_o = '0;
        end else if (rd_q.gated) begin
            ram_rdata_o = GATE;
        end else if (rd_q.fwd) begin
            ram_rdata_o = rd_q.fdata;
        end else begin
            ram_rdata_o = arr_rdata;
        end
    end

    assign ram_rvalid_o = rd_q.rvalid;

    AST_COMMIT_ENABLED: assert property (@(posedge clk) disable iff (!por_n)
        arr_we |-> en[arr_waddr[AW-1 -: PB]]); // R6
    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(commit_v)); // R7
    AST_GATED_READ: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        (ram_req_i && !ram_wr_i && !standby_i && !en[page]) |=> (ram_rvalid_o && ram_rdata_o == GATE)); // R6
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        standby_i |=> !ram_rvalid_o); // R3
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        (ram_req_i && !ram_wr_i && !standby_i) |=> ram_rvalid_o); // R4

endmodule

// File: tb/pgram_ctrl_bench.sv
`timescale 1ns/1ps
module pgram_ctrl_bench;

    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] GATE = 32'hDEAD_BEEF;

    logic          clk = 1'b0;
    logic          por_n, mrst_n, standby;
    logic          reg_sel, reg_wr;
    logic [1:0]    reg_size;
    logic [7:0]    reg_wdata, reg_rdata;
    logic          ram_req, ram_wr, ram_ifetch;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata, ram_rdata;
    logic          ram_rvalid;

    always #2.5 clk = ~clk;

    pgram_ctrl #(.AW(AW), .DW(DW)) u_pgram_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .mrst_n       (mrst_n),
        .standby_i    (standby),
        .reg_sel_i    (reg_sel),
        .reg_wr_i     (reg_wr),
        .reg_size_i   (reg_size),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .ram_req_i    (ram_req),
        .ram_wr_i     (ram_wr),
        .ram_ifetch_i (ram_ifetch),
        .ram_addr_i   (ram_addr),
        .ram_wdata_i  (ram_wdata),
        .ram_rdata_o  (ram_rdata),
        .ram_rvalid_o (ram_rvalid)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] m_mem [DEPTH];
    logic [3:0]    m_en;
    logic          m_bv [4];
    logic [AW-1:0] m_ba [4];
    logic [DW-1:0] m_bd [4];

    function automatic int pg(input logic [AW-1:0] a);
        return int'(a[AW-1 -: 2]);
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        int p = pg(a);
        if (!m_en[p]) return GATE;
        if (m_bv[p] && m_ba[p] == a) return m_bd[p];
        return m_mem[a];
    endfunction

    function automatic logic [7:0] exp_reg();
        return {4'hF, m_en};
    endfunction

    task automatic model_ram(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int p = pg(a);
        if (!m_en[p]) return;
        if (m_bv[p]) m_mem[m_ba[p]] = m_bd[p];
        if (wr) begin
            m_bv[p] = 1'b1; m_ba[p] = a; m_bd[p] = d;
        end else begin
            m_bv[p] = 1'b0;
        end
    endtask

    task automatic model_reg(input logic [1:0] sz, input logic [7:0] d);
        if (sz != 2'b00) return;
        for (int p = 0; p < 4; p++) begin
            if (m_en[p] && !d[p]) m_bv[p] = 1'b0;
        end
        m_en = d[3:0];
    endtask

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        standby = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_size = 2'b00; reg_wdata = '0;
        ram_req = 1'b0; ram_wr = 1'b0; ram_ifetch = 1'b0; ram_addr = '0; ram_wdata = '0;
    endtask

    task automatic cycle(input bit do_ram, input bit wr, input bit fetch,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit do_reg, input logic [1:0] sz, input logic [7:0] rv,
                         input string tag);
        logic [DW-1:0] exp = exp_read(a);
        ram_req = do_ram; ram_wr = wr; ram_ifetch = fetch; ram_addr = a; ram_wdata = d;
        reg_sel = do_reg; reg_wr = do_reg; reg_size = sz; reg_wdata = rv;
        @(posedge clk);
        #1;
        idle();
        if (do_ram) model_ram(wr, a, d);
        if (do_reg) model_reg(sz, rv);
        if (do_ram && !wr) begin
            check(DW'(ram_rvalid), 32'd1, {tag, " rvalid"});
            check(ram_rdata, exp, tag);
        end
        if (do_reg) check(DW'(reg_rdata), DW'(exp_reg()), {tag, " reg"});
    endtask

    task automatic wr_ram(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        cycle(1, 1, 0, a, d, 0, 2'b00, 8'h00, tag);
    endtask

    task automatic rd_ram(input logic [AW-1:0] a, input string tag);
        cycle(1, 0, 0, a, '0, 0, 2'b00, 8'h00, tag);
    endtask

    task automatic wr_reg(input logic [1:0] sz, input logic [7:0] v, input string tag);
        cycle(0, 0, 0, '0, '0, 1, sz, v, tag);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        idle();
        por_n = 1'b0; mrst_n = 1'b1;
        m_en = 4'hF;
        for (int p = 0; p < 4; p++) begin
            m_bv[p] = 1'b0; m_ba[p] = '0; m_bd[p] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(DW'(reg_rdata), 32'h0000_00FF, "R1 reset value");
        check(DW'(ram_rvalid), 32'd0, "R1 rvalid at reset");
        por_n = 1'b1;
        @(posedge clk); #1;

        for (int a = 0; a < DEPTH; a++) begin
            wr_ram(AW'(a), (32'h0101_0101 * a) ^ 32'h5A5A_0000, "fill");
        end

        // R5 forwarding of a parked write, and R4 fetch path
        wr_ram(8'h05, 32'h1111_0005, "R5 park");
        rd_ram(8'h05, "R5 forward read");
        cycle(1, 0, 1, 8'h05, '0, 0, 2'b00, 8'h00, "R4 fetch read");
        rd_ram(8'h45, "R5 page1 read");

        // R7 commit by same-page write, R8 loss without flush
        wr_ram(8'h06, 32'hAAAA_0006, "R7 first write");
        wr_ram(8'h09, 32'hBBBB_0009, "R7 second write");
        wr_reg(2'b00, 8'h0E, "R8 clear page0");
        wr_reg(2'b00, 8'h0F, "R8 set page0");
        rd_ram(8'h06, "R7 committed value");
        rd_ram(8'h09, "R8 lost write");

        // R7 other pages do not commit
        wr_ram(8'h85, 32'hCCCC_0085, "R7 park page2");
        rd_ram(8'hC3, "R7 page3 read");
        wr_ram(8'h43, 32'hCCCC_0043, "R7 page1 write");
        wr_reg(2'b00, 8'h0B, "R8 clear page2");
        wr_reg(2'b00, 8'h0F, "R8 set page2");
        rd_ram(8'h85, "R7 no cross-page commit");

        // R6 gated page
        wr_reg(2'b00, 8'h0D, "R6 clear page1");
        wr_ram(8'h50, 32'hDDDD_0050, "R6 dropped write");
        rd_ram(8'h50, "R6 gated read");
        cycle(1, 0, 1, 8'h51, '0, 0, 2'b00, 8'h00, "R6 gated fetch");
        wr_reg(2'b00, 8'h0F, "R6 set page1");
        rd_ram(8'h50, "R6 array unchanged");

        // R2 size handling
        wr_reg(2'b01, 8'h00, "R2 word ignored");
        wr_reg(2'b10, 8'h00, "R2 long ignored");
        wr_reg(2'b00, 8'hF7, "R2 byte write");
        wr_reg(2'b00, 8'h0F, "R2 byte restore");

        // R3 standby freezes both ports
        wr_ram(8'hC7, 32'hEEEE_00C7, "R3 park");
        rd_ram(8'hC7, "R3 commit");
        standby = 1'b1; reg_sel = 1'b1; reg_wr = 1'b1; reg_size = 2'b00; reg_wdata = 8'h00;
        ram_req = 1'b1; ram_wr = 1'b1; ram_addr = 8'hC7; ram_wdata = 32'h0BAD_0BAD;
        @(posedge clk); #1;
        ram_wr = 1'b0;
        @(posedge clk); #1;
        check(DW'(ram_rvalid), 32'd0, "R3 no read in standby");
        idle();
        check(DW'(reg_rdata), 32'h0000_00FF, "R3 reg kept in standby");
        rd_ram(8'hC7, "R3 write ignored in standby");

        // R10 manual reset
        wr_ram(8'h8A, 32'h7777_008A, "R10 park");
        rd_ram(8'h40, "R10 read before reset");
        mrst_n = 1'b0;
        #1;
        check(DW'(ram_rvalid), 32'd0, "R10 rvalid cleared");
        @(posedge clk); #1;
        mrst_n = 1'b1;
        check(DW'(reg_rdata), DW'(exp_reg()), "R3 reg kept over manual reset");
        rd_ram(8'h8A, "R10 parked write kept");

        // R9 collision: clear page0 while writing page0
        wr_ram(8'h0A, 32'h9999_000A, "R9 park older");
        cycle(1, 1, 0, 8'h0B, 32'h9999_000B, 1, 2'b00, 8'h0E, "R9 collide write");
        rd_ram(8'h0A, "R9 next cycle uses new enables");
        wr_reg(2'b00, 8'h0F, "R9 set page0");
        rd_ram(8'h0A, "R9 older entry committed");
        rd_ram(8'h0B, "R9 newer write discarded");
        // R9 re-enable and access next cycle
        wr_reg(2'b00, 8'h07, "R9 clear page3");
        cycle(1, 0, 0, 8'hC1, '0, 1, 2'b00, 8'h0F, "R9 read under old enables");
        rd_ram(8'hC1, "R9 read under new enables");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 100);
            logic [AW-1:0] a = AW'($urandom);
            logic [DW-1:0] d = $urandom;
            logic [7:0] rv = 8'($urandom) | 8'(($urandom % 3 != 0) ? 8'h0F : 8'h00);
            if (r < 6) begin
                wr_reg(2'b00, rv, "R2 random reg");
            end else if (r < 9) begin
                wr_reg(2'(1 + $urandom % 2), rv, "R2 random nonbyte");
            end else if (r < 16) begin
                cycle(1, 1'($urandom), 1'($urandom), a, d, 1, 2'b00, rv, "R9 random collision");
            end else if (r < 55) begin
                wr_ram(a, d, "R7 random write");
            end else begin
                cycle(1, 0, 1'($urandom), a, '0, 0, 2'b00, 8'h00, "R5 random read");
            end
        end

        wr_reg(2'b00, 8'h0F, "R8 final enable");
        for (int p = 0; p < 4; p++) begin
            rd_ram(AW'(p * 64 + 17), "R5 final read");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule